// File: doc/BRIEF.md
# Power-Management Event Interrupt Router

This block gathers interrupt requests from six peripheral functions (printer port, floppy controller, serial channel A, infrared serial channel, watchdog timer and general-purpose I/O). Each request lands in a sticky status bit, which software clears by writing a one to it. Any status bit whose per-source enable is set makes the block raise an event. A configuration register sends that event to a system-management interrupt (SMI) line or to a power-management event (PME) line, and a master output enable can silence both lines without stopping the status bits from recording.

A small synchronous register port gives read and write access to the configuration, status and enable registers. The block also holds a device-idle expiry timer that counts a 1 kHz tick input. It reloads on any device activity pulse and gives a single-cycle strobe when the idle window runs out. A configuration bit selects a long window (1 s) or a short one (8 ms).

Top module: `pm_event_router`

## Requirements
- R1: After reset every register reads 0x00, and `smiOut`, `pmeOut` and `idleExpired` are all low.
- R2: With the output enable set, a pending event drives `smiOut` when the route-select bit is 0 and drives `pmeOut` when it is 1. The two lines are never high together.
- R3: With the output enable clear, both `smiOut` and `pmeOut` stay low, and incoming requests still set their status bits.
- R4: A status bit is set by a rising edge of its `irqIn` line. A level held high does not set the bit again after it has been cleared.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: If a rising request edge arrives in the same cycle as a write-one-to-clear of its bit, the bit ends up set.
- R7: An output line is high only while at least one status bit and its matching enable bit are both set. It drops in the cycle after the last such bit is cleared.
- R8: Register map on `regAddr`. Address 0 is configuration: bit 0 output enable, bit 1 fast expiry, bit 2 route select. Address 1 is status A: bit 3 printer, bit 2 floppy, bit 1 serial A, bit 0 infrared. Address 2 is status B: bit 3 GPIO, bit 2 watchdog. Addresses 3 and 4 hold the enables in the same bit layout as addresses 1 and 2. `irqIn` bits 0..5 are infrared, serial A, floppy, printer, watchdog, GPIO.
- R9: Bits with no function read as zero, and addresses 5 to 7 read 0x00.
- R10: After a reload, the idle timer pulses `idleExpired` high for exactly one cycle on the 8th `idleTick` when fast expiry is 1, and on the 1000th when it is 0. It then stays quiet until the next activity pulse.
- R11: A `devActivity` pulse reloads the idle timer. When an activity pulse and a tick arrive in the same cycle, the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 6 | Peripheral interrupt requests, rising edge sets status |
| regAddr | input | 3 | Register address for read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational from `regAddr`) |
| idleTick | input | 1 | 1 kHz timebase tick, one cycle wide |
| devActivity | input | 1 | Device activity pulse, reloads the idle timer |
| smiOut | output | 1 | System-management interrupt request level |
| pmeOut | output | 1 | Power-management event request level |
| idleExpired | output | 1 | One-cycle idle expiry strobe |

## Verification
The routing function is exercised with a table of configuration, enable and request patterns. Single sources go to each target, several sources fire together, the output enable is off, and the enable masks do not match the active source. Together these separate a routing fault from a masking fault and from a status capture fault. Directed sequences then cover a level held across a clear, a request edge that coincides with a clear, writes of zero, reserved bits and unmapped addresses. The idle timer is counted in both windows, including a reload that lands in the same cycle as a tick.

// File: rtl/pm_router_pkg.sv
package pm_router_pkg;

  localparam int REG_ADDR_W = 3;
  localparam int REG_DATA_W = 8;
  localparam int NUM_SRC    = 6;

  localparam logic [REG_ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STSA = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_STSB = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_ENA  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_ENB  = 3'd4;

  // Source index inside the internal vectors
  localparam int SRC_IR   = 0;
  localparam int SRC_SERA = 1;
  localparam int SRC_FDC  = 2;
  localparam int SRC_PRT  = 3;
  localparam int SRC_WDT  = 4;
  localparam int SRC_GPIO = 5;

  // Bit positions of the group-B sources inside their register
  localparam int BPOS_WDT  = 2;
  localparam int BPOS_GPIO = 3;

  typedef enum logic [2:0] {
    SEL_CFG, SEL_STSA, SEL_STSB, SEL_ENA, SEL_ENB, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    wrCfg;
    logic    wrStsA;
    logic    wrStsB;
    logic    wrEnA;
    logic    wrEnB;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/pm_router_ctrl.sv
module pm_router_ctrl
  import pm_router_pkg::*;
(
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output ctrlStrobes_t          strobes
);

  always_comb begin
    strobes = '{wrCfg: 1'b0, wrStsA: 1'b0, wrStsB: 1'b0,
                wrEnA: 1'b0, wrEnB: 1'b0, rdSel: SEL_NONE};
    case (regAddr)
      ADDR_CFG:  begin strobes.wrCfg  = regWrEn; strobes.rdSel = SEL_CFG;  end
      ADDR_STSA: begin strobes.wrStsA = regWrEn; strobes.rdSel = SEL_STSA; end
      ADDR_STSB: begin strobes.wrStsB = regWrEn; strobes.rdSel = SEL_STSB; end
      ADDR_ENA:  begin strobes.wrEnA  = regWrEn; strobes.rdSel = SEL_ENA;  end
      ADDR_ENB:  begin strobes.wrEnB  = regWrEn; strobes.rdSel = SEL_ENB;  end
      default:   strobes.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/pm_router_dp.sv
module pm_router_dp
  import pm_router_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [REG_DATA_W-1:0] wrData,
  input  logic [NUM_SRC-1:0]    irqIn,
  output logic [REG_DATA_W-1:0] rdData,
  output logic                  smiOut,
  output logic                  pmeOut,
  output logic                  fastExpiry,
  output logic                  outEnable,
  output logic [NUM_SRC-1:0]    statusVec
);

  logic                  routeToPme;
  logic [NUM_SRC-1:0]    enableVec;
  logic [NUM_SRC-1:0]    irqPrev;
  logic [NUM_SRC-1:0]    riseVec;
  logic [NUM_SRC-1:0]    clearVec;
  logic [NUM_SRC-1:0]    wrMapped;
  logic                  pending;
  logic                  unusedHiBits;

  assign unusedHiBits = ^wrData[REG_DATA_W-1:4];

  // Write data laid out in source order (group A low nibble, group B picked bits)
  always_comb begin
    wrMapped           = '0;
    wrMapped[SRC_PRT:SRC_IR] = wrData[3:0];
    wrMapped[SRC_WDT]  = wrData[BPOS_WDT];
    wrMapped[SRC_GPIO] = wrData[BPOS_GPIO];
  end

  always_comb begin
    clearVec = '0;
    if (strobes.wrStsA) clearVec[SRC_PRT:SRC_IR] = wrMapped[SRC_PRT:SRC_IR];
    if (strobes.wrStsB) clearVec[SRC_GPIO:SRC_WDT] = wrMapped[SRC_GPIO:SRC_WDT];
  end

  assign riseVec = irqIn & ~irqPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev    <= '0;
      statusVec  <= '0;
      enableVec  <= '0;
      outEnable  <= 1'b0;
      fastExpiry <= 1'b0;
      routeToPme <= 1'b0;
    end else begin
      irqPrev   <= irqIn;
      // set has priority over clear so that no edge is lost
      statusVec <= (statusVec & ~clearVec) | riseVec;
      if (strobes.wrEnA) enableVec[SRC_PRT:SRC_IR]   <= wrMapped[SRC_PRT:SRC_IR];
      if (strobes.wrEnB) enableVec[SRC_GPIO:SRC_WDT] <= wrMapped[SRC_GPIO:SRC_WDT];
      if (strobes.wrCfg) begin
        outEnable  <= wrData[0];
        fastExpiry <= wrData[1];
        routeToPme <= wrData[2];
      end
    end
  end

  assign pending = |(statusVec & enableVec);
  assign smiOut  = pending & outEnable & ~routeToPme;
  assign pmeOut  = pending & outEnable &  routeToPme;

  function automatic logic [REG_DATA_W-1:0] packGroupB(input logic [NUM_SRC-1:0] v);
    logic [REG_DATA_W-1:0] r;
    r            = '0;
    r[BPOS_WDT]  = v[SRC_WDT];
    r[BPOS_GPIO] = v[SRC_GPIO];
    return r;
  endfunction

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      SEL_CFG:  rdData[2:0] = {routeToPme, fastExpiry, outEnable};
      SEL_STSA: rdData[3:0] = statusVec[SRC_PRT:SRC_IR];
      SEL_STSB: rdData      = packGroupB(statusVec);
      SEL_ENA:  rdData[3:0] = enableVec[SRC_PRT:SRC_IR];
      SEL_ENB:  rdData      = packGroupB(enableVec);
      default:  rdData      = '0;
    endcase
  end

endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic fastSel,
  input  logic tick,
  input  logic activity,
  output logic expired
);

  localparam int CNT_W = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             doneFlag;
  logic [CNT_W-1:0] lastVal;

  assign lastVal = fastSel ? SHORT_LAST : LONG_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      doneFlag <= 1'b0;
      expired  <= 1'b0;
    end else if (activity) begin
      tickCnt  <= '0;
      doneFlag <= 1'b0;
      expired  <= 1'b0;
    end else if (tick && !doneFlag) begin
      if (tickCnt >= lastVal) begin
        expired  <= 1'b1;
        doneFlag <= 1'b1;
      end else begin
        tickCnt  <= tickCnt + 1'b1;
        expired  <= 1'b0;
      end
    end else begin
      expired <= 1'b0;
    end
  end

endmodule

// File: rtl/pm_event_router.sv
module pm_event_router
  import pm_router_pkg::*;
#(
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    irqIn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  input  logic                  idleTick,
  input  logic                  devActivity,
  output logic                  smiOut,
  output logic                  pmeOut,
  output logic                  idleExpired
);

  ctrlStrobes_t       strobes;
  logic               fastExpiry;
  logic               outEnable;
  logic [NUM_SRC-1:0] statusVec;

  pm_router_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  pm_router_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (regWrData),
    .irqIn      (irqIn),
    .rdData     (regRdData),
    .smiOut     (smiOut),
    .pmeOut     (pmeOut),
    .fastExpiry (fastExpiry),
    .outEnable  (outEnable),
    .statusVec  (statusVec)
  );

  pm_idle_timer #(
    .LONG_TICKS  (LONG_TICKS),
    .SHORT_TICKS (SHORT_TICKS)
  ) uTimer (
    .clk      (clk),
    .rstN     (rstN),
    .fastSel  (fastExpiry),
    .tick     (idleTick),
    .activity (devActivity),
    .expired  (idleExpired)
  );

endmodule

// File: rtl/pm_event_router_chk.sv
module pm_event_router_chk
  import pm_router_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqIn,
  input logic               smiOut,
  input logic               pmeOut,
  input logic               idleExpired,
  input logic               devActivity,
  input logic               outEnable,
  input logic [NUM_SRC-1:0] statusVec
);

  // R2: the event goes to one target at most
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !(smiOut && pmeOut));

  // R3: master enable off silences both lines
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> (!smiOut && !pmeOut));

  // R7: an output needs a recorded status bit behind it
  a_r7_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    (smiOut || pmeOut) |-> (statusVec != '0));

  // R4 and R6: every rising request edge leaves its bit set, even against a clear
  for (genvar k = 0; k < NUM_SRC; k++) begin : gEdge
    a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqIn[k]) |=> statusVec[k]);
  end

  // R10: the expiry strobe lasts a single cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    idleExpired |=> !idleExpired);

  // R11: an activity pulse never yields an expiry in the next cycle
  a_r11_reload_quiet: assert property (@(posedge clk) disable iff (!rstN)
    devActivity |=> !idleExpired);

endmodule

bind pm_event_router pm_event_router_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .irqIn       (irqIn),
  .smiOut      (smiOut),
  .pmeOut      (pmeOut),
  .idleExpired (idleExpired),
  .devActivity (devActivity),
  .outEnable   (outEnable),
  .statusVec   (statusVec)
);

// File: tb/pm_event_router_test.sv
module pm_event_router_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] irqIn = '0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       idleTick = 1'b0;
  logic       devActivity = 1'b0;
  logic       smiOut, pmeOut, idleExpired;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  pm_event_router uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .idleTick(idleTick), .devActivity(devActivity),
    .smiOut(smiOut), .pmeOut(pmeOut), .idleExpired(idleExpired)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] enA;
    logic [7:0] enB;
    logic [5:0] irq;
    logic [7:0] stsA;
    logic [7:0] stsB;
    logic       smi;
    logic       pme;
  } vec_t;

  // cfg: bit0 output enable, bit1 fast expiry, bit2 route select (R8)
  localparam vec_t VECS [8] = '{
    '{8'h01, 8'h0F, 8'h0C, 6'b000001, 8'h01, 8'h00, 1'b1, 1'b0}, // R2 IR to SMI
    '{8'h05, 8'h0F, 8'h0C, 6'b001000, 8'h08, 8'h00, 1'b0, 1'b1}, // R2 printer to PME
    '{8'h04, 8'h0F, 8'h0C, 6'b010000, 8'h00, 8'h04, 1'b0, 1'b0}, // R3 disabled, wdt
    '{8'h01, 8'h00, 8'h00, 6'b111111, 8'h0F, 8'h0C, 1'b0, 1'b0}, // R7 all masked
    '{8'h01, 8'h02, 8'h00, 6'b000100, 8'h04, 8'h00, 1'b0, 1'b0}, // R7 mismatch
    '{8'h05, 8'h00, 8'h08, 6'b100000, 8'h00, 8'h08, 1'b0, 1'b1}, // R7 gpio to PME
    '{8'h07, 8'h00, 8'h04, 6'b010010, 8'h02, 8'h04, 1'b0, 1'b1}, // R2 mixed to PME
    '{8'h03, 8'h06, 8'h00, 6'b000110, 8'h06, 8'h00, 1'b1, 1'b0}  // R2 two sources SMI
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic tickOnce();
    idleTick = 1'b1;
    @(negedge clk);
    idleTick = 1'b0;
  endtask

  task automatic activityOnce();
    devActivity = 1'b1;
    @(negedge clk);
    devActivity = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    logic       early;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1", "reset readback", d, 8'h00);
    end
    chk("R1", "reset outputs", {5'b0, smiOut, pmeOut, idleExpired}, 8'h00);

    // Table walk (R2, R3, R7, R8)
    foreach (VECS[i]) begin
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'hFF);
      wr(3'd3, VECS[i].enA);
      wr(3'd4, VECS[i].enB);
      wr(3'd0, VECS[i].cfg);
      irqIn = VECS[i].irq;
      @(negedge clk);
      irqIn = '0;
      chk("R2", $sformatf("vec%0d smi/pme", i), {6'b0, smiOut, pmeOut},
          {6'b0, VECS[i].smi, VECS[i].pme});
      rd(3'd1, d);
      chk("R8", $sformatf("vec%0d status A", i), d, VECS[i].stsA);
      rd(3'd2, d);
      chk("R3", $sformatf("vec%0d status B", i), d, VECS[i].stsB);
      rd(3'd0, d);
      chk("R8", $sformatf("vec%0d cfg readback", i), d, VECS[i].cfg & 8'h07);
    end

    // R9 reserved bits and unmapped addresses
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd0, 8'hF8);
    rd(3'd0, d); chk("R9", "cfg reserved", d, 8'h00);
    wr(3'd3, 8'hF0);
    rd(3'd3, d); chk("R9", "enA reserved", d, 8'h00);
    wr(3'd4, 8'hF3);
    rd(3'd4, d); chk("R9", "enB reserved", d, 8'h00);
    wr(3'd5, 8'hFF);
    rd(3'd5, d); chk("R9", "addr5", d, 8'h00);
    rd(3'd7, d); chk("R9", "addr7", d, 8'h00);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); chk("R8", "enB layout", d, 8'h0C);

    // R5 write zero keeps, write one clears
    irqIn = 6'b001111; @(negedge clk); irqIn = '0;
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R5", "write 0 no effect", d, 8'h0F);
    wr(3'd1, 8'h02);
    rd(3'd1, d); chk("R5", "write 1 clears bit1", d, 8'h0D);
    wr(3'd1, 8'h0D);
    rd(3'd1, d); chk("R5", "all cleared", d, 8'h00);

    // R7 output drops when last pending bit cleared
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h01);
    irqIn = 6'b000001; @(negedge clk); irqIn = '0;
    chk("R7", "smi high", {7'b0, smiOut}, 8'h01);
    wr(3'd1, 8'h01);
    chk("R7", "smi dropped", {7'b0, smiOut}, 8'h00);

    // R4 held level does not re-set after clear
    irqIn = 6'b000001; @(negedge clk);
    wr(3'd1, 8'h01);
    @(negedge clk);
    rd(3'd1, d); chk("R4", "held level stays clear", d, 8'h00);
    irqIn = '0; @(negedge clk);
    irqIn = 6'b000001; @(negedge clk); irqIn = '0;
    rd(3'd1, d); chk("R4", "new edge sets", d, 8'h01);
    wr(3'd1, 8'h01);

    // R6 edge coinciding with clear
    irqIn = 6'b001000; @(negedge clk); irqIn = '0; @(negedge clk);
    regAddr = 3'd1; regWrData = 8'h08; regWrEn = 1'b1; irqIn = 6'b001000;
    @(negedge clk);
    regWrEn = 1'b0; irqIn = '0;
    rd(3'd1, d); chk("R6", "set wins over clear", d, 8'h08);
    wr(3'd1, 8'h08);
    rd(3'd1, d); chk("R5", "later clear works", d, 8'h00);

    // R10 fast window
    wr(3'd0, 8'h02);
    activityOnce();
    early = 1'b0;
    for (int t = 0; t < 7; t++) begin
      tickOnce();
      if (idleExpired) early = 1'b1;
    end
    chk("R10", "no early fast expiry", {7'b0, early}, 8'h00);
    tickOnce();
    chk("R10", "fast expiry on 8th tick", {7'b0, idleExpired}, 8'h01);
    @(negedge clk);
    chk("R10", "strobe one cycle", {7'b0, idleExpired}, 8'h00);
    early = 1'b0;
    for (int t = 0; t < 12; t++) begin
      tickOnce();
      if (idleExpired) early = 1'b1;
    end
    chk("R10", "quiet after expiry", {7'b0, early}, 8'h00);

    // R11 reload mid count and against a tick
    activityOnce();
    for (int t = 0; t < 5; t++) tickOnce();
    activityOnce();
    early = 1'b0;
    for (int t = 0; t < 7; t++) begin
      tickOnce();
      if (idleExpired) early = 1'b1;
    end
    idleTick = 1'b1; devActivity = 1'b1;
    @(negedge clk);
    idleTick = 1'b0; devActivity = 1'b0;
    if (idleExpired) early = 1'b1;
    for (int t = 0; t < 7; t++) begin
      tickOnce();
      if (idleExpired) early = 1'b1;
    end
    chk("R11", "reload delays expiry", {7'b0, early}, 8'h00);
    tickOnce();
    chk("R11", "expiry 8 ticks after reload", {7'b0, idleExpired}, 8'h01);

    // R10 long window
    wr(3'd0, 8'h00);
    activityOnce();
    early = 1'b0;
    for (int t = 0; t < 999; t++) begin
      tickOnce();
      if (idleExpired) early = 1'b1;
    end
    chk("R10", "no early long expiry", {7'b0, early}, 8'h00);
    tickOnce();
    chk("R10", "long expiry on 1000th tick", {7'b0, idleExpired}, 8'h01);
    @(negedge clk);
    chk("R10", "long strobe one cycle", {7'b0, idleExpired}, 8'h00);

    finishRun();
  end

endmodule